// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Control

This block serialises characters onto an asynchronous line. It is paced by a one-cycle enable pulse (`tick16`) that arrives sixteen times per bit period. Every bit cell lasts sixteen of these ticks, and the line rests high. A character is written into a single holding register. When the shift engine is free, it takes the character and sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop interval. The stop interval is programmed in sixteenths of a bit.

The line format comes from static mode inputs. These are the character length, the parity mode and its select bit, and the stop code. They are captured at the moment a character moves from the holding register into the shifter, so a character already on the line keeps its own format. An optional clear-to-send gate prevents a new character from starting while `cts` is low. A break request forces the line low until a stop-break request clears it.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame starts with a start bit of 0 lasting 16 ticks. The data bits follow least significant bit first, one 16-tick cell each. `len_code` sets the count: 2'b00 = 5 bits, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8.
- R3: `par_mode` 2'b10 sends no parity cell. `par_mode` 2'b00 sends a 16-tick parity cell that makes the count of ones over data and parity even when `par_sel` = 0 and odd when `par_sel` = 1.
- R4: `par_mode` 2'b01 (forced) sends `par_sel` in the parity cell, where 0 is space and 1 is mark. `par_mode` 2'b11 (multidrop) sends `par_sel` in that cell as the address/data flag.
- R5: The stop interval holds the line at 1 for 9 + `stop_code[2:0]` ticks. `stop_code[3]` = 1 adds 16 ticks, and 5-bit characters add 8 more. A character waiting in the holding register starts on the tick right after the last stop tick.
- R6: With `cts_gate_en` = 1 and `cts` = 0, no new character starts. A character already in progress finishes in full if `cts` drops during it. With `cts_gate_en` = 0, `cts` has no effect.
- R7: A `brk_start` pulse drives `txd` to 0 from the next cycle. `txd` stays 0 until a `brk_stop` pulse, and is released on the cycle after that pulse.
- R8: `tx_ready` is 1 exactly when the holding register is free, and falls the cycle after an accepted write. `tx_empty` is 1 only when the holding register is free and the shifter is idle.
- R9: A write while `tx_ready` = 0 is ignored, and the held character is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| len_code | input | 2 | Character length code |
| par_mode | input | 2 | Parity mode: normal, forced, none, multidrop |
| par_sel | input | 1 | Parity type, forced level, or address flag |
| stop_code | input | 4 | Stop interval code |
| cts_gate_en | input | 1 | Enables gating of character start on `cts` |
| cts | input | 1 | Clear to send, active high |
| brk_start | input | 1 | Start-break pulse |
| brk_stop | input | 1 | Stop-break pulse |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
`tx_ready` and `tx_empty` change one clock after the write edge, and the shifter takes the character on the following edge. The bench therefore reads those flags at the falling edge one and two cycles after the write. The line is checked one tick at a time: the monitor samples `txd` at each falling edge where `tick16` is high, which is the tick that the next rising edge counts. The stop length is confirmed in two ways. For a single character, `tx_empty` must be 0 at the last stop tick and 1 one cycle later. For back-to-back characters, the next start bit must appear at the very next tick. Break and the clear-to-send hold are checked one cycle after the request, and again after a long wait.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int OSR    = 16;
    localparam int DATA_W = 8;
    localparam int MIN_W  = 5;
    localparam int STOP_MAX = 2 * OSR + OSR / 2;
    localparam int CNT_W  = $clog2(STOP_MAX + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_FORCED = 2'b01,
        PM_NONE   = 2'b10,
        PM_ADDR   = 2'b11
    } par_mode_e;

    function automatic logic [CNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                    input logic [1:0] len);
        logic [CNT_W-1:0] t;
        t = CNT_W'(9) + CNT_W'(code[2:0]);
        if (code[3])
            t = t + CNT_W'(OSR);
        if (len == 2'b00)
            t = t + CNT_W'(OSR / 2);
        return t;
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d,
                                     input logic [1:0] len,
                                     input logic [1:0] mode,
                                     input logic sel);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_W + int'(len))
                x = x ^ d[i];
        end
        case (mode)
            PM_NORMAL: return x ^ sel;
            PM_FORCED: return sel;
            PM_ADDR:   return sel;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (take)
            h_d.full = 1'b0;
        if (wr_en && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            h_q <= '0;
        else
            h_q <= h_d;
    end

    assign full = h_q.full;
    assign data = h_q.data;

    // A refused write must leave the held character untouched
    p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.full && wr_en && !take) |=> $stable(h_q.data));

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic active
);

    logic brk_q, brk_d;

    always_comb begin
        brk_d = brk_q;
        if (clr_req)
            brk_d = 1'b0;
        if (set_req)
            brk_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_q <= 1'b0;
        else
            brk_q <= brk_d;
    end

    assign active = brk_q;

    p_brk_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !clr_req) |=> brk_q);

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              par_sel,
    input  logic [3:0]        stop_code,
    input  logic              cts_gate_en,
    input  logic              cts,
    output logic              take,
    output logic              line,
    output logic              idle
);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last_idx;
        logic              par_en;
        logic              par_v;
        logic [CNT_W-1:0]  stop_len;
    } frame_t;

    frame_t f_q, f_d, f_load;
    logic   can_go;
    logic   cell_end;
    logic   stop_end;

    // Snapshot of a fresh character and its format
    always_comb begin
        f_load          = f_q;
        f_load.st       = ST_START;
        f_load.cnt      = '0;
        f_load.sh       = hold_data;
        f_load.idx      = '0;
        f_load.last_idx = IDX_W'(MIN_W - 1 + int'(len_code));
        f_load.par_en   = (par_mode != PM_NONE);
        f_load.par_v    = par_bit(hold_data, len_code, par_mode, par_sel);
        f_load.stop_len = stop_ticks(stop_code, len_code);
    end

    assign can_go   = hold_full && (!cts_gate_en || cts);
    assign cell_end = tick && (f_q.cnt == CNT_W'(OSR - 1));
    assign stop_end = tick && (f_q.cnt == f_q.stop_len - 1'b1);

    always_comb begin
        f_d  = f_q;
        take = 1'b0;
        if (tick && f_q.st != ST_IDLE)
            f_d.cnt = f_q.cnt + 1'b1;
        case (f_q.st)
            ST_IDLE: begin
                if (can_go) begin
                    f_d  = f_load;
                    take = 1'b1;
                end
            end
            ST_START: begin
                if (cell_end) begin
                    f_d.st  = ST_DATA;
                    f_d.cnt = '0;
                end
            end
            ST_DATA: begin
                if (cell_end) begin
                    f_d.cnt = '0;
                    if (f_q.idx == f_q.last_idx) begin
                        f_d.st = f_q.par_en ? ST_PAR : ST_STOP;
                    end else begin
                        f_d.idx = f_q.idx + 1'b1;
                        f_d.sh  = f_q.sh >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (cell_end) begin
                    f_d.st  = ST_STOP;
                    f_d.cnt = '0;
                end
            end
            ST_STOP: begin
                if (stop_end) begin
                    if (can_go) begin
                        f_d  = f_load;
                        take = 1'b1;
                    end else begin
                        f_d.st  = ST_IDLE;
                        f_d.cnt = '0;
                    end
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q          <= '0;
            f_q.st       <= ST_IDLE;
            f_q.stop_len <= CNT_W'(OSR);
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        case (f_q.st)
            ST_START: line = 1'b0;
            ST_DATA:  line = f_q.sh[0];
            ST_PAR:   line = f_q.par_v;
            default:  line = 1'b1;
        endcase
    end

    assign idle = (f_q.st == ST_IDLE);

    // A gated idle shifter stays idle on the next cycle
    p_cts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_IDLE && cts_gate_en && !cts) |=> (f_q.st == ST_IDLE));

    // Tick counter never passes the longest stop interval
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_IDLE) |-> (f_q.cnt < CNT_W'(STOP_MAX)));

endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              par_sel,
    input  logic [3:0]        stop_code,
    input  logic              cts_gate_en,
    input  logic              cts,
    input  logic              brk_start,
    input  logic              brk_stop,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              line;
    logic              sh_idle;
    logic              brk_on;

    uart_tx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .len_code    (len_code),
        .par_mode    (par_mode),
        .par_sel     (par_sel),
        .stop_code   (stop_code),
        .cts_gate_en (cts_gate_en),
        .cts         (cts),
        .take        (take),
        .line        (line),
        .idle        (sh_idle)
    );

    uart_tx_brk u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (brk_start),
        .clr_req (brk_stop),
        .active  (brk_on)
    );

    assign txd      = brk_on ? 1'b0 : line;
    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && sh_idle;

    p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !txd);

    p_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

endmodule

// File: tb/uart_tx_frac_tb_top.sv
module uart_tx_frac_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_code = 2'b11;
    logic [1:0] par_mode = 2'b10;
    logic       par_sel = 1'b0;
    logic [3:0] stop_code = 4'd7;
    logic       cts_gate_en = 1'b0;
    logic       cts = 1'b1;
    logic       brk_start = 1'b0;
    logic       brk_stop = 1'b0;
    logic       txd, tx_ready, tx_empty;

    always #5 clk = ~clk;

    always @(posedge clk) tick16 <= ~tick16;

    uart_tx_frac dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .len_code(len_code), .par_mode(par_mode), .par_sel(par_sel), .stop_code(stop_code),
        .cts_gate_en(cts_gate_en), .cts(cts), .brk_start(brk_start), .brk_stop(brk_stop),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    typedef struct {
        logic [7:0] data;
        logic [1:0] len;
        logic [1:0] pm;
        logic       ps;
        logic [3:0] sc;
        bit         follow;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit   mon_en = 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor / scoreboard
    logic wave [0:255];
    int   wlen = 0, pos = 0, bad = 0, first_bad = -1;
    bit   busy = 0, want_low = 0, chk_empty = 0;
    exp_t cur;

    task automatic build_wave(exp_t e);
        int idx = 0;
        int nb = 5 + int'(e.len);
        logic x = 1'b0;
        for (int k = 0; k < 16; k++) begin wave[idx] = 1'b0; idx++; end
        for (int b = 0; b < nb; b++) begin
            x = x ^ e.data[b];
            for (int k = 0; k < 16; k++) begin wave[idx] = e.data[b]; idx++; end
        end
        if (e.pm != 2'b10) begin
            logic p = (e.pm == 2'b00) ? (x ^ e.ps) : e.ps;
            for (int k = 0; k < 16; k++) begin wave[idx] = p; idx++; end
        end
        begin
            int st = 9 + int'(e.sc[2:0]) + (e.sc[3] ? 16 : 0) + (e.len == 2'b00 ? 8 : 0);
            for (int k = 0; k < st; k++) begin wave[idx] = 1'b1; idx++; end
        end
        wlen = idx;
    endtask

    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (chk_empty) begin
                chk_empty = 0;
                check(tx_empty == 1'b1, cur.tag, "tx_empty one cycle after last stop tick", tx_empty, 1);
            end
            if (tick16) begin
                if (!busy) begin
                    if (want_low) begin
                        want_low = 0;
                        check(txd == 1'b0, cur.tag, "next start at tick after last stop tick", txd, 0);
                    end
                    if (txd == 1'b0) begin
                        if (q.size() == 0) begin
                            check(0, "R9", "frame with no queued character", 1, 0);
                        end else begin
                            cur = q.pop_front();
                            build_wave(cur);
                            pos = 1; bad = 0; first_bad = -1; busy = 1;
                        end
                    end
                end else begin
                    if (txd !== wave[pos]) begin
                        if (bad == 0) first_bad = pos;
                        bad++;
                    end
                    pos++;
                    if (pos == wlen) begin
                        busy = 0;
                        check(bad == 0, cur.tag, "frame first wrong tick index", first_bad, -1);
                        if (cur.follow) want_low = 1;
                        else begin
                            check(tx_empty == 1'b0, cur.tag, "tx_empty during last stop tick", tx_empty, 0);
                            chk_empty = 1;
                        end
                    end
                end
            end
        end
    end

    // Driver
    task automatic send(logic [7:0] d, logic [1:0] len, logic [1:0] pm, logic ps,
                        logic [3:0] sc, bit follow, string tag);
        exp_t e;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        len_code = len; par_mode = pm; par_sel = ps; stop_code = sc;
        wr_data = d; wr_en = 1'b1;
        e.data = d; e.len = len; e.pm = pm; e.ps = ps; e.sc = sc; e.follow = follow; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!(tx_empty && !busy && q.size() == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
        check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);

        // R2: lengths, no parity
        send(8'hA5, 2'b11, 2'b10, 1'b0, 4'd7, 0, "R2"); wait_done();
        send(8'h3C, 2'b10, 2'b10, 1'b0, 4'd7, 0, "R2"); wait_done();
        send(8'h15, 2'b01, 2'b10, 1'b0, 4'd7, 0, "R2"); wait_done();
        send(8'h1B, 2'b00, 2'b10, 1'b0, 4'd7, 0, "R2"); wait_done();

        // R3: normal parity even / odd
        send(8'h96, 2'b11, 2'b00, 1'b0, 4'd7, 0, "R3"); wait_done();
        send(8'h96, 2'b11, 2'b00, 1'b1, 4'd7, 0, "R3"); wait_done();
        send(8'h47, 2'b10, 2'b00, 1'b1, 4'd7, 0, "R3"); wait_done();

        // R4: forced and multidrop
        send(8'h5A, 2'b11, 2'b01, 1'b0, 4'd7, 0, "R4"); wait_done();
        send(8'h5A, 2'b11, 2'b01, 1'b1, 4'd7, 0, "R4"); wait_done();
        send(8'h0F, 2'b11, 2'b11, 1'b1, 4'd7, 0, "R4"); wait_done();

        // R5: stop lengths, back-to-back and single
        send(8'h81, 2'b11, 2'b10, 1'b0, 4'd0, 1, "R5");
        send(8'h7E, 2'b11, 2'b10, 1'b0, 4'd0, 0, "R5"); wait_done();
        send(8'hC6, 2'b11, 2'b00, 1'b0, 4'd15, 1, "R5");
        send(8'h39, 2'b11, 2'b00, 1'b0, 4'd15, 0, "R5"); wait_done();
        send(8'h0A, 2'b00, 2'b10, 1'b0, 4'd4, 0, "R5"); wait_done();
        send(8'h13, 2'b00, 2'b01, 1'b1, 4'd12, 0, "R5"); wait_done();

        // R6 / R8 / R9: gated start
        cts_gate_en = 1'b1; cts = 1'b0;
        send(8'h55, 2'b11, 2'b00, 1'b1, 4'd7, 0, "R9");
        check(tx_ready == 1'b0, "R8", "tx_ready after accepted write", tx_ready, 0);
        check(tx_empty == 1'b0, "R8", "tx_empty after accepted write", tx_empty, 0);
        repeat (100) @(negedge clk);
        check(txd == 1'b1, "R6", "line held idle while cts low", txd, 1);
        check(tx_ready == 1'b0, "R6", "character still held while cts low", tx_ready, 0);
        wr_data = 8'hFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(tx_ready == 1'b0, "R9", "tx_ready after refused write", tx_ready, 0);
        cts = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(tx_ready == 1'b1, "R8", "tx_ready after shifter takes character", tx_ready, 1);
        check(tx_empty == 1'b0, "R8", "tx_empty while shifting", tx_empty, 0);
        wait_done();

        // R6: cts drops mid-frame
        send(8'hC3, 2'b11, 2'b00, 1'b0, 4'd7, 0, "R6");
        repeat (60) @(negedge clk);
        cts = 1'b0;
        wait_done();
        check(txd == 1'b1, "R6", "line idle after completed frame", txd, 1);
        cts = 1'b1;

        // R6: gating disabled ignores cts
        cts_gate_en = 1'b0; cts = 1'b0;
        send(8'h81, 2'b11, 2'b10, 1'b0, 4'd7, 0, "R6"); wait_done();
        cts = 1'b1;

        // R7: break
        mon_en = 0;
        @(negedge clk); brk_start = 1'b1;
        @(negedge clk); brk_start = 1'b0;
        check(txd == 1'b0, "R7", "txd cycle after break start", txd, 0);
        repeat (80) @(negedge clk);
        check(txd == 1'b0, "R7", "txd held in break", txd, 0);
        brk_stop = 1'b1;
        @(negedge clk); brk_stop = 1'b0;
        check(txd == 1'b1, "R7", "txd after break stop", txd, 1);
        mon_en = 1;

        check(q.size() == 0, "R9", "pending expected frames", q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule